// File: doc/BRIEF.md
# Per-CPU Private Down-Counting Timer Pair

This block holds the two private timers that belong to one processor core. Timer 0 is the general-purpose timer and timer 1 is the watchdog-style timer. Each timer has a reload value, a live down-counter, a control word and a sticky expiry flag. While it is enabled and holds a non-zero count, a timer decrements once every `divider + 1` clock cycles. When the count runs out, the expiry flag is set. The counter then either restarts from the reload value or stays at zero.

Software reaches both timers through one small register window. Address bit 5 selects the timer. Address bits 3:2 select the register: offset 0x0 is the reload value, 0x4 the live counter, 0x8 the control word and 0xC the expiry flag. All other address bits are ignored. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`.

Each timer drives a one-cycle private-interrupt request, but only when its expiry flag goes from clear to set and its interrupt enable is on. A flag that stays set never requests again. Alongside the request vector, the block reports the interrupt number of the requester: `ID_BASE` (29) for the general timer and `ID_BASE + 1` (30) for the watchdog timer.

Top module: `priv_timer_pair`

## Requirements
- R1: After reset, every register of both timers reads 0, `irq_pulse` is 0 and `irq_id` is 0.
- R2: The control word keeps enable in bit 0, auto-reload in bit 1, interrupt enable in bit 2 and the divider in bits 15:8. All other bits read 0. A write to one timer (address bit 5) leaves the other timer unchanged, and the reload value reads back as written.
- R3: Writing the reload register also loads the live counter. The counter register returns the live count while the timer is enabled and returns 0 while it is disabled.
- R4: An enabled timer with a non-zero count decrements once every `divider + 1` cycles. A disabled timer keeps its count, and the kept count reads back again after the timer is re-enabled. Any write to a timer restarts its divider phase.
- R5: After a load of N with divider p, the expiry flag (bit 0 of offset 0xC) reads 1 exactly N*(p+1) cycles after the load edge and not one cycle earlier. Without auto-reload, the counter then stays at 0.
- R6: With auto-reload set, an expiry puts the reload value back into the counter, and counting continues from there.
- R7: A count of zero never arms the timer and never sets the expiry flag.
- R8: Writing 1 to bit 0 of offset 0xC clears the expiry flag. Writing 0 there leaves the flag unchanged. The flag falls only on such a write.
- R9: `irq_pulse[k]` is high for exactly one cycle: the first cycle in which timer k's expiry flag reads 1 after having been 0. An expiry while the flag is already set raises no request.
- R10: With interrupt enable (control bit 2) clear, an expiry sets the flag but raises no request.
- R11: `irq_id` is `ID_BASE` (29) when timer 0 requests and `ID_BASE + 1` (30) when only timer 1 requests. When both request together it shows 29, and it is 0 when neither requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address: bit 5 selects the timer, bits 3:2 select the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_pulse | output | 2 | One-cycle private-interrupt requests, bit k for timer k |
| irq_id | output | ID_W | Interrupt number of the lowest-indexed requester, 0 when idle |

## Verification
Some rules hold on every cycle, and the embedded properties check them there. A request never lasts two cycles. The expiry flag falls only on a write of 1 to the flag register. The count never grows except on a write or a reload. A disabled timer holds its count. A zero count never raises the flag. A lone watchdog request reports number 30. The directed scenarios cover what depends on exact cycle counts and on values read back: the expiry lands exactly N*(p+1) cycles after the load, the counter reads 0 while disabled and the kept value afterwards, and the reload restarts the count. They also show that a write of 0 to the flag changes nothing, that a second expiry stays silent until the flag is cleared, and that simultaneous requests from both timers report number 29.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   typedef enum logic [1:0] {
      RS_LOAD  = 2'd0,
      RS_COUNT = 2'd1,
      RS_CTRL  = 2'd2,
      RS_STAT  = 2'd3
   } reg_sel_e;

   localparam int CTRL_EN      = 0;
   localparam int CTRL_RELOAD  = 1;
   localparam int CTRL_IE      = 2;
   localparam int CTRL_DIV_LSB = 8;
   localparam int STAT_EXP     = 0;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               restart_i,
   input  logic [PRESC_W-1:0] div_i,
   output logic               tick_o
);
   logic [PRESC_W-1:0] pre_q;
   logic               wrap;

   assign wrap   = (pre_q == div_i);
   assign tick_o = run_i && !restart_i && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pre_q <= '0;
      else if (restart_i) pre_q <= '0;
      else if (run_i)     pre_q <= wrap ? '0 : pre_q + PRESC_W'(1);
   end

   // R4
   presc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !restart_i) |-> (pre_q <= div_i));
endmodule

// File: rtl/ptmr_irq_edge.sv
module ptmr_irq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_i,
   input  logic ie_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= stat_i;
   end

   assign pulse_o = stat_i && !prev_q && ie_i;

   // R9
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
   import ptmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PRESC_W = 8,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  reg_sel_e          reg_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              stat_o,
   output logic              ie_o
);
   logic [CNT_W-1:0]   load_q, cnt_q;
   logic [PRESC_W-1:0] div_q;
   logic               en_q, rl_q, ie_q, stat_q;
   logic               wr_load, wr_cnt, wr_ctrl, wr_stat;
   logic               armed, tick, expire;

   assign wr_load = wr_i && (reg_i == RS_LOAD);
   assign wr_cnt  = wr_i && (reg_i == RS_COUNT);
   assign wr_ctrl = wr_i && (reg_i == RS_CTRL);
   assign wr_stat = wr_i && (reg_i == RS_STAT);
   assign armed   = en_q && (cnt_q != '0);
   assign expire  = tick && (cnt_q == CNT_W'(1));

   ptmr_prescaler #(.PRESC_W(PRESC_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (armed),
      .restart_i (wr_i),
      .div_i     (div_q),
      .tick_o    (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         cnt_q  <= '0;
         div_q  <= '0;
         en_q   <= 1'b0;
         rl_q   <= 1'b0;
         ie_q   <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q  <= wdata_i[CTRL_EN];
            rl_q  <= wdata_i[CTRL_RELOAD];
            ie_q  <= wdata_i[CTRL_IE];
            div_q <= wdata_i[CTRL_DIV_LSB +: PRESC_W];
         end
         if (wr_load) load_q <= wdata_i[CNT_W-1:0];
         if (wr_load || wr_cnt) cnt_q <= wdata_i[CNT_W-1:0];
         else if (expire)       cnt_q <= rl_q ? load_q : '0;
         else if (tick)         cnt_q <= cnt_q - CNT_W'(1);
         if (expire)                          stat_q <= 1'b1;
         else if (wr_stat && wdata_i[STAT_EXP]) stat_q <= 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (reg_i)
         RS_LOAD:  rdata_o[CNT_W-1:0] = load_q;
         RS_COUNT: rdata_o[CNT_W-1:0] = en_q ? cnt_q : '0;
         RS_CTRL: begin
            rdata_o[CTRL_EN]                    = en_q;
            rdata_o[CTRL_RELOAD]                = rl_q;
            rdata_o[CTRL_IE]                    = ie_q;
            rdata_o[CTRL_DIV_LSB +: PRESC_W]    = div_q;
         end
         default:  rdata_o[STAT_EXP] = stat_q;
      endcase
   end

   assign stat_o = stat_q;
   assign ie_o   = ie_q;

   // R7
   zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !wr_i) |=> !$rose(stat_q));
   // R8
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q) |-> $past(wr_stat && wdata_i[STAT_EXP]));
   // R4
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !wr_i) |=> $stable(cnt_q));
   // R5
   cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && !expire) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/priv_timer_pair.sv
module priv_timer_pair
   import ptmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PRESC_W = 8,
   parameter int ID_BASE = 29,
   parameter int ID_W    = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [5:0]      addr,
   input  logic [31:0]     wdata,
   output logic [31:0]     rdata,
   output logic [1:0]      irq_pulse,
   output logic [ID_W-1:0] irq_id
);
   localparam int NT     = 2;
   localparam int DATA_W = 32;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("priv_timer_pair: CNT_W out of range");
   end
   if (PRESC_W < 1 || PRESC_W > 8) begin : g_bad_div
      $error("priv_timer_pair: PRESC_W must be 1..8");
   end
   if (ID_BASE < 1 || ID_BASE + NT > (1 << ID_W)) begin : g_bad_id
      $error("priv_timer_pair: ID_BASE does not fit ID_W");
   end

   reg_sel_e          reg_sel;
   logic              tsel;
   logic [DATA_W-1:0] rd_arr [NT];
   logic              unused_addr_bits;

   assign reg_sel          = reg_sel_e'(addr[3:2]);
   assign tsel             = addr[5];
   assign unused_addr_bits = ^{addr[4], addr[1:0]};

   for (genvar k = 0; k < NT; k++) begin : g_tmr
      logic stat, ie;

      ptmr_core #(.CNT_W(CNT_W), .PRESC_W(PRESC_W), .DATA_W(DATA_W)) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (wr_en && (tsel == k[0])),
         .reg_i   (reg_sel),
         .wdata_i (wdata),
         .rdata_o (rd_arr[k]),
         .stat_o  (stat),
         .ie_o    (ie)
      );

      ptmr_irq_edge u_edge (
         .clk     (clk),
         .rst_n   (rst_n),
         .stat_i  (stat),
         .ie_i    (ie),
         .pulse_o (irq_pulse[k])
      );
   end

   assign rdata = rd_arr[tsel];

   always_comb begin
      irq_id = '0;
      for (int k = NT - 1; k >= 0; k--) begin
         if (irq_pulse[k]) irq_id = ID_W'(ID_BASE + k);
      end
   end

   // R11
   wdg_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse == 2'b10) |-> (irq_id == ID_W'(ID_BASE + 1)));
endmodule

// File: tb/sim_priv_timer_pair.sv
module sim_priv_timer_pair;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  irq_pulse;
   logic [4:0]  irq_id;

   int checks = 0;
   int failures = 0;

   priv_timer_pair u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_pulse(irq_pulse), .irq_id(irq_id)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   localparam logic [1:0] LD = 2'd0, CN = 2'd1, CT = 2'd2, ST = 2'd3;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // caller stands just after a falling edge; the write lands on the next rising edge
   task automatic wr(input logic t, input logic [1:0] r, input logic [31:0] d);
      wr_en = 1'b1;
      addr  = {t, 1'b0, r, 2'b00};
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string tag, input logic t, input logic [1:0] r, input logic [31:0] exp);
      addr = {t, 1'b0, r, 2'b00};
      #1;
      check(tag, rdata, exp);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic test_reset();
      do_reset();
      for (int t = 0; t < 2; t++) begin
         for (int r = 0; r < 4; r++) rd("R1 reg after reset", t[0], r[1:0], 32'h0);
      end
      check("R1 pulse after reset", {30'd0, irq_pulse}, 32'h0);
      check("R1 id after reset", {27'd0, irq_id}, 32'h0);
   endtask

   task automatic test_regmap();
      do_reset();
      wr(1'b1, CT, 32'hFFFF_FFFF);
      wr(1'b1, LD, 32'h1234_5678);
      rd("R2 ctrl readback", 1'b1, CT, 32'h0000_FF07);
      rd("R2 load readback", 1'b1, LD, 32'h1234_5678);
      rd("R2 other timer ctrl", 1'b0, CT, 32'h0);
      wait_n(1);
      rd("R2 other timer load", 1'b0, LD, 32'h0);
   endtask

   task automatic test_oneshot();
      do_reset();
      wr(1'b0, CT, 32'h0000_0205);
      wr(1'b0, LD, 32'd3);
      wait_n(4);
      rd("R3 live count", 1'b0, CN, 32'd2);
      wait_n(4);
      rd("R5 flag not early", 1'b0, ST, 32'd0);
      wait_n(1);
      rd("R5 flag at expiry", 1'b0, ST, 32'd1);
      rd("R5 count stops at zero", 1'b0, CN, 32'd0);
      check("R9 pulse on rise", {30'd0, irq_pulse}, 32'd1);
      check("R11 id general", {27'd0, irq_id}, 32'd29);
      wait_n(1);
      check("R9 pulse one cycle", {30'd0, irq_pulse}, 32'd0);
      wait_n(6);
      rd("R5 count stays zero", 1'b0, CN, 32'd0);
      rd("R7 no re-expiry flag", 1'b0, ST, 32'd1);
   endtask

   task automatic test_hold();
      do_reset();
      wr(1'b0, CT, 32'h0000_0001);
      wr(1'b0, LD, 32'd10);
      wait_n(3);
      rd("R4 decrement each cycle", 1'b0, CN, 32'd7);
      wr(1'b0, CT, 32'h0000_0000);
      rd("R3 disabled reads zero", 1'b0, CN, 32'd0);
      wait_n(5);
      wr(1'b0, CT, 32'h0000_0001);
      rd("R4 count held while off", 1'b0, CN, 32'd7);
   endtask

   task automatic test_reload();
      do_reset();
      wr(1'b0, CT, 32'h0000_0007);
      wr(1'b0, LD, 32'd4);
      wait_n(4);
      rd("R6 reload at expiry", 1'b0, CN, 32'd4);
      rd("R5 flag set", 1'b0, ST, 32'd1);
      check("R9 first pulse", {30'd0, irq_pulse}, 32'd1);
      wait_n(1);
      rd("R6 counting resumes", 1'b0, CN, 32'd3);
      wait_n(3);
      check("R9 no refire while set", {30'd0, irq_pulse}, 32'd0);
      wr(1'b0, ST, 32'd0);
      rd("R8 write zero ignored", 1'b0, ST, 32'd1);
      wr(1'b0, ST, 32'd1);
      rd("R8 write one clears", 1'b0, ST, 32'd0);
      wait_n(3);
      check("R9 no pulse before expiry", {30'd0, irq_pulse}, 32'd0);
      wait_n(1);
      check("R9 pulse after clear", {30'd0, irq_pulse}, 32'd1);
   endtask

   task automatic test_zero();
      do_reset();
      wr(1'b1, CT, 32'h0000_0007);
      wr(1'b1, LD, 32'd0);
      wait_n(20);
      rd("R7 zero never expires", 1'b1, ST, 32'd0);
      rd("R7 zero count reads zero", 1'b1, CN, 32'd0);
      check("R7 no pulse", {30'd0, irq_pulse}, 32'd0);
   endtask

   task automatic test_gate();
      do_reset();
      wr(1'b0, CT, 32'h0000_0001);
      wr(1'b0, LD, 32'd2);
      wait_n(2);
      rd("R10 flag set without ie", 1'b0, ST, 32'd1);
      check("R10 no pulse without ie", {30'd0, irq_pulse}, 32'd0);
   endtask

   task automatic test_ids();
      do_reset();
      wr(1'b0, CT, 32'h0000_0005);
      wr(1'b1, CT, 32'h0000_0005);
      wr(1'b1, LD, 32'd1);
      wait_n(1);
      check("R11 watchdog pulse", {30'd0, irq_pulse}, 32'd2);
      check("R11 watchdog id", {27'd0, irq_id}, 32'd30);
      do_reset();
      wr(1'b0, CT, 32'h0000_0005);
      wr(1'b1, CT, 32'h0000_0005);
      wr(1'b0, LD, 32'd3);
      wr(1'b1, LD, 32'd2);
      wait_n(2);
      check("R11 both pulse", {30'd0, irq_pulse}, 32'd3);
      check("R11 both id", {27'd0, irq_id}, 32'd29);
      wait_n(1);
      check("R11 idle id", {27'd0, irq_id}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      test_reset();
      test_regmap();
      test_oneshot();
      test_hold();
      test_reload();
      test_zero();
      test_gate();
      test_ids();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule